// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Flags

This block is a first-in first-out buffer for 9-bit words. A producer on one clock pushes words in, and a consumer on a second clock pops them out. The two clocks may be the same net or fully unrelated. Each side is gated by a pair of enables, and an operation happens only when both are high. The registered read data can be turned off with an output-enable input. When it is off, the block reports through a separate drive-enable output that the data bus would float, and it drives zeros on the data bus.

Four status flags come out. Empty and almost-empty change on the read clock. Full and almost-full change on the write clock. The two almost thresholds are held in offset registers and can be set to any word count. At reset both offsets take the value 7. The level of the second write enable during reset selects one of two modes:

- Dual-enable mode: the second write enable is an ordinary enable.
- Load mode: a cycle with the first write enable high and the second low loads one offset byte from the data input instead of writing a word.

A small four-state loader sequences these byte loads. Its states are `LD_AE_LO`, `LD_AE_HI`, `LD_AF_LO` and `LD_AF_HI`. Each load moves it to the next state, and after `LD_AF_HI` it returns to `LD_AE_LO`. Reset places it in `LD_AE_LO`.

Top module: `xclk_fifo`

## Requirements
- R1: A word is stored on a write-clock rising edge only when wr_en1 and wr_en2 are both 1 and full is 0. A cycle with only one of the two enables high stores nothing.
- R2: A word is removed on a read-clock rising edge only when rd_en1 and rd_en2 are both 1 and empty is 0. A cycle with only one of the two enables high removes nothing and leaves rd_q unchanged.
- R3: A write attempted while full is dropped. The stored contents and their order are unchanged.
- R4: A read attempted while empty changes neither rd_q nor the read position. The next word written is the next word read.
- R5: Words leave in the order they were written. A popped word appears on rd_q right after the read edge that removed it, and rd_q holds its value between reads.
- R6: rd_q_en equals rd_oe. While rd_oe is 0, rd_q is all zeros; while rd_oe is 1, rd_q shows the output register.
- R7: After reset, empty=1, aempty=1, full=0, afull=0 and rd_q=0, and both offsets are 7.
- R8: empty falls on the third read-clock edge after the write edge that filled an empty buffer. empty rises on the read edge that takes the last word.
- R9: full rises on the write edge that stores the last free word. full falls on the third write-clock edge after the read edge that frees a slot.
- R10: Once settled with n words held, aempty = (n <= almost-empty offset) and afull = (n >= 2^AW - almost-full offset). The offsets are counted in single words.
- R11: If wr_en2 is 0 during reset, load mode is selected. In load mode, a cycle with wr_en1=1 and wr_en2=0 loads one byte, in this order: almost-empty offset low part, almost-empty high part, almost-full low part, almost-full high part, then back to the start. The low part is offset bits [LO_W-1:0], taken from wr_data[LO_W-1:0]. The high part is offset bits [AW-1:LO_W], taken from wr_data[AW-LO_W-1:0], where LO_W=(AW+1)/2. Other data bits are ignored.
- R12: If wr_en2 is 1 during reset, dual-enable mode is selected. In this mode a cycle with wr_en1=1 and wr_en2=0 changes neither offset and stores no word.
- R13: With the two clocks at unrelated periods, every word written is read back once, in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| rd_clk | input | 1 | Read-side clock |
| rst_n | input | 1 | Active-low master reset, sampled by both clocks |
| wr_en1 | input | 1 | First write enable |
| wr_en2 | input | 1 | Second write enable; acts as the load control in load mode; its level during reset picks the mode |
| wr_data | input | DW | Word to store, or offset byte to load |
| rd_en1 | input | 1 | First read enable |
| rd_en2 | input | 1 | Second read enable |
| rd_oe | input | 1 | Output enable for the read data |
| rd_q | output | DW | Registered read data, zero while disabled |
| rd_q_en | output | 1 | Drive enable for rd_q (low means the bus would float) |
| full | output | 1 | No free slot (write clock) |
| afull | output | 1 | Almost full (write clock) |
| empty | output | 1 | No word held (read clock) |
| aempty | output | 1 | Almost empty (read clock) |

## Verification
Full, empty and the popped data are all due at the same edge as the operation that causes them. Almost-full follows writes at that same edge. The edges that cross from the other side take three edges of the receiving clock, because a two-stage synchronizer sits in front of the flag register. The latency checks therefore count falling edges after the triggering edge and sample the third and fourth of them, and the third must still show the old value. The flag sweeps wait four idle cycles after each single push or pop before they compare all four flags with the arithmetic formula for the current word count. The check on the popped word is made at the falling edge right after the read.

// File: rtl/dcf_pkg.sv
package dcf_pkg;
    typedef enum logic [1:0] {
        LD_AE_LO,
        LD_AE_HI,
        LD_AF_LO,
        LD_AF_HI
    } ld_state_t;

    localparam int DEF_OFS = 7;
endpackage

// File: rtl/dcf_sync.sv
module dcf_sync #(
    parameter int W = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1 <= '0;
            q      <= '0;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/dcf_ram.sv
module dcf_ram #(
    parameter int DW = 9,
    parameter int AW = 6
) (
    input  logic          wr_clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge wr_clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/dcf_wr_ctl.sv
module dcf_wr_ctl
    import dcf_pkg::*;
#(
    parameter int DW = 9,
    parameter int AW = 6
) (
    input  logic          wr_clk,
    input  logic          rst_n,
    input  logic          wr_en1,
    input  logic          wr_en2,
    input  logic [DW-1:0] wr_data,
    input  logic [AW:0]   rgray_s,
    output logic [AW:0]   wbin,
    output logic [AW:0]   wgray,
    output logic          full,
    output logic          afull,
    output logic [AW-1:0] ae_ofs,
    output logic [AW-1:0] af_ofs,
    output logic          mode_ld,
    output logic          ram_we,
    output logic [AW-1:0] ram_waddr
);
    localparam int DEPTH = 1 << AW;
    localparam int LO_W  = (AW + 1) / 2;
    localparam int HI_W  = AW - LO_W;
    localparam logic [AW:0] FULL_CNT = (AW+1)'(DEPTH);

    function automatic logic [AW:0] g2b(input logic [AW:0] g);
        logic [AW:0] b;
        b[AW] = g[AW];
        for (int i = AW - 1; i >= 0; i--) b[i] = b[i+1] ^ g[i];
        return b;
    endfunction

    ld_state_t   st_q, st_d;
    logic        put, ld;
    logic        ae_lo_we, ae_hi_we, af_lo_we, af_hi_we;
    logic [AW:0] wbin_d, rbin_s, cnt_d;

    // Mode is captured from the second enable while reset is held.
    always_ff @(posedge wr_clk) begin
        if (!rst_n) mode_ld <= ~wr_en2;
    end

    assign put = wr_en1 & wr_en2 & ~full;
    assign ld  = mode_ld & wr_en1 & ~wr_en2;

    // Offset loader: state register
    always_ff @(posedge wr_clk) begin
        if (!rst_n) st_q <= LD_AE_LO;
        else        st_q <= st_d;
    end

    // Offset loader: next state and byte strobes
    always_comb begin
        st_d     = st_q;
        ae_lo_we = 1'b0;
        ae_hi_we = 1'b0;
        af_lo_we = 1'b0;
        af_hi_we = 1'b0;
        if (ld) begin
            unique case (st_q)
                LD_AE_LO: begin ae_lo_we = 1'b1; st_d = LD_AE_HI; end
                LD_AE_HI: begin ae_hi_we = 1'b1; st_d = LD_AF_LO; end
                LD_AF_LO: begin af_lo_we = 1'b1; st_d = LD_AF_HI; end
                LD_AF_HI: begin af_hi_we = 1'b1; st_d = LD_AE_LO; end
            endcase
        end
    end

    always_ff @(posedge wr_clk) begin
        if (!rst_n) begin
            ae_ofs <= AW'(DEF_OFS);
            af_ofs <= AW'(DEF_OFS);
        end else begin
            if (ae_lo_we) ae_ofs[LO_W-1:0]  <= wr_data[LO_W-1:0];
            if (ae_hi_we) ae_ofs[AW-1:LO_W] <= wr_data[HI_W-1:0];
            if (af_lo_we) af_ofs[LO_W-1:0]  <= wr_data[LO_W-1:0];
            if (af_hi_we) af_ofs[AW-1:LO_W] <= wr_data[HI_W-1:0];
        end
    end

    assign wbin_d = wbin + (AW+1)'(put);
    assign rbin_s = g2b(rgray_s);
    assign cnt_d  = wbin_d - rbin_s;

    always_ff @(posedge wr_clk) begin
        if (!rst_n) begin
            wbin  <= '0;
            wgray <= '0;
            full  <= 1'b0;
            afull <= 1'b0;
        end else begin
            wbin  <= wbin_d;
            wgray <= wbin_d ^ (wbin_d >> 1);
            full  <= (cnt_d == FULL_CNT);
            afull <= (cnt_d >= (FULL_CNT - {1'b0, af_ofs}));
        end
    end

    assign ram_we    = put;
    assign ram_waddr = wbin[AW-1:0];
endmodule

// File: rtl/dcf_rd_ctl.sv
module dcf_rd_ctl #(
    parameter int DW = 9,
    parameter int AW = 6
) (
    input  logic          rd_clk,
    input  logic          rst_n,
    input  logic          rd_en1,
    input  logic          rd_en2,
    input  logic [AW:0]   wgray_s,
    input  logic [AW-1:0] ae_ofs,
    input  logic [DW-1:0] ram_rdata,
    output logic [AW-1:0] ram_raddr,
    output logic [AW:0]   rbin,
    output logic [AW:0]   rgray,
    output logic          empty,
    output logic          aempty,
    output logic [DW-1:0] q_r
);
    function automatic logic [AW:0] g2b(input logic [AW:0] g);
        logic [AW:0] b;
        b[AW] = g[AW];
        for (int i = AW - 1; i >= 0; i--) b[i] = b[i+1] ^ g[i];
        return b;
    endfunction

    logic        get;
    logic [AW:0] rbin_d, wbin_s, cnt_d;

    assign get    = rd_en1 & rd_en2 & ~empty;
    assign rbin_d = rbin + (AW+1)'(get);
    assign wbin_s = g2b(wgray_s);
    assign cnt_d  = wbin_s - rbin_d;

    always_ff @(posedge rd_clk) begin
        if (!rst_n) begin
            rbin   <= '0;
            rgray  <= '0;
            empty  <= 1'b1;
            aempty <= 1'b1;
            q_r    <= '0;
        end else begin
            rbin   <= rbin_d;
            rgray  <= rbin_d ^ (rbin_d >> 1);
            empty  <= (cnt_d == '0);
            aempty <= (cnt_d <= {1'b0, ae_ofs});
            if (get) q_r <= ram_rdata;
        end
    end

    assign ram_raddr = rbin[AW-1:0];
endmodule

// File: rtl/xclk_fifo.sv
module xclk_fifo #(
    parameter int DW = 9,
    parameter int AW = 6
) (
    input  logic          wr_clk,
    input  logic          rd_clk,
    input  logic          rst_n,
    input  logic          wr_en1,
    input  logic          wr_en2,
    input  logic [DW-1:0] wr_data,
    input  logic          rd_en1,
    input  logic          rd_en2,
    input  logic          rd_oe,
    output logic [DW-1:0] rd_q,
    output logic          rd_q_en,
    output logic          full,
    output logic          afull,
    output logic          empty,
    output logic          aempty
);
    logic [AW:0]   wbin, wgray, wgray_s;
    logic [AW:0]   rbin, rgray, rgray_s;
    logic [AW-1:0] ae_ofs, af_ofs;
    logic          mode_ld;
    logic          ram_we;
    logic [AW-1:0] ram_waddr, ram_raddr;
    logic [DW-1:0] ram_rdata, q_r;

    dcf_wr_ctl #(.DW(DW), .AW(AW)) u_wr (
        .wr_clk(wr_clk), .rst_n(rst_n), .wr_en1(wr_en1), .wr_en2(wr_en2),
        .wr_data(wr_data), .rgray_s(rgray_s), .wbin(wbin), .wgray(wgray),
        .full(full), .afull(afull), .ae_ofs(ae_ofs), .af_ofs(af_ofs),
        .mode_ld(mode_ld), .ram_we(ram_we), .ram_waddr(ram_waddr)
    );

    dcf_sync #(.W(AW + 1)) u_r2w (
        .clk(wr_clk), .rst_n(rst_n), .d(rgray), .q(rgray_s)
    );

    dcf_sync #(.W(AW + 1)) u_w2r (
        .clk(rd_clk), .rst_n(rst_n), .d(wgray), .q(wgray_s)
    );

    dcf_ram #(.DW(DW), .AW(AW)) u_ram (
        .wr_clk(wr_clk), .we(ram_we), .waddr(ram_waddr), .wdata(wr_data),
        .raddr(ram_raddr), .rdata(ram_rdata)
    );

    dcf_rd_ctl #(.DW(DW), .AW(AW)) u_rd (
        .rd_clk(rd_clk), .rst_n(rst_n), .rd_en1(rd_en1), .rd_en2(rd_en2),
        .wgray_s(wgray_s), .ae_ofs(ae_ofs), .ram_rdata(ram_rdata),
        .ram_raddr(ram_raddr), .rbin(rbin), .rgray(rgray), .empty(empty),
        .aempty(aempty), .q_r(q_r)
    );

    assign rd_q_en = rd_oe;
    assign rd_q    = rd_oe ? q_r : '0;
endmodule

// File: rtl/dcf_chk.sv
module dcf_chk #(
    parameter int DW = 9,
    parameter int AW = 6
) (
    input logic          wr_clk,
    input logic          rd_clk,
    input logic          rst_n,
    input logic          wr_en1,
    input logic          wr_en2,
    input logic          rd_en1,
    input logic          rd_en2,
    input logic          full,
    input logic          afull,
    input logic          empty,
    input logic          aempty,
    input logic [AW:0]   wbin,
    input logic [AW:0]   rbin,
    input logic [DW-1:0] q_r,
    input logic          mode_ld,
    input logic [AW-1:0] ae_ofs,
    input logic [AW-1:0] af_ofs
);
    p_no_overflow_r3: assert property (@(posedge wr_clk) disable iff (!rst_n)
        (full && wr_en1 && wr_en2) |=> $stable(wbin));

    p_no_underflow_r4: assert property (@(posedge rd_clk) disable iff (!rst_n)
        (empty && rd_en1 && rd_en2) |=> $stable(rbin));

    p_q_hold_r5: assert property (@(posedge rd_clk) disable iff (!rst_n)
        !(rd_en1 && rd_en2 && !empty) |=> $stable(q_r));

    p_wptr_step_r1: assert property (@(posedge wr_clk) disable iff (!rst_n)
        1'b1 |=> (wbin == $past(wbin)) || (wbin == $past(wbin) + 1'b1));

    p_rptr_step_r2: assert property (@(posedge rd_clk) disable iff (!rst_n)
        1'b1 |=> (rbin == $past(rbin)) || (rbin == $past(rbin) + 1'b1));

    p_full_afull_r10: assert property (@(posedge wr_clk) disable iff (!rst_n)
        full |-> afull);

    p_empty_aempty_r10: assert property (@(posedge rd_clk) disable iff (!rst_n)
        empty |-> aempty);

    p_ofs_locked_r12: assert property (@(posedge wr_clk) disable iff (!rst_n)
        !mode_ld |=> ($stable(ae_ofs) && $stable(af_ofs)));
endmodule

bind xclk_fifo dcf_chk #(.DW(DW), .AW(AW)) u_chk (
    .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n),
    .wr_en1(wr_en1), .wr_en2(wr_en2), .rd_en1(rd_en1), .rd_en2(rd_en2),
    .full(full), .afull(afull), .empty(empty), .aempty(aempty),
    .wbin(wbin), .rbin(rbin), .q_r(q_r), .mode_ld(mode_ld),
    .ae_ofs(ae_ofs), .af_ofs(af_ofs)
);

// File: tb/xclk_fifo_test.sv
module xclk_fifo_test;
    localparam int CLK_PERIOD  = 10;
    localparam int RCLK_PERIOD = 14;
    localparam int DW    = 9;
    localparam int AW    = 6;
    localparam int DEPTH = 1 << AW;

    logic wclk = 1'b0, rclk_free = 1'b0, tied = 1'b1;
    wire  rd_clk = tied ? wclk : rclk_free;

    logic          rst_n = 1'b0;
    logic          wr_en1 = 1'b0, wr_en2 = 1'b1;
    logic [DW-1:0] wr_data = '0;
    logic          rd_en1 = 1'b0, rd_en2 = 1'b0, rd_oe = 1'b1;
    logic [DW-1:0] rd_q;
    logic          rd_q_en, full, afull, empty, aempty;

    int  n_checks = 0;
    int  n_errs   = 0;
    bit  finished = 1'b0;
    logic [DW-1:0] mq[$];

    always #(CLK_PERIOD/2)  wclk = ~wclk;
    always #(RCLK_PERIOD/2) rclk_free = ~rclk_free;

    xclk_fifo #(.DW(DW), .AW(AW)) uut (
        .wr_clk(wclk), .rd_clk(rd_clk), .rst_n(rst_n),
        .wr_en1(wr_en1), .wr_en2(wr_en2), .wr_data(wr_data),
        .rd_en1(rd_en1), .rd_en2(rd_en2), .rd_oe(rd_oe),
        .rd_q(rd_q), .rd_q_en(rd_q_en), .full(full), .afull(afull),
        .empty(empty), .aempty(aempty)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errs++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // flags packed as {empty, aempty, full, afull}
    task automatic chk_flags(input string tag, input int n, input int aeo, input int afo);
        int exp, act;
        exp = {28'd0, n == 0, n <= aeo, n == DEPTH, n >= DEPTH - afo};
        act = {28'd0, empty, aempty, full, afull};
        chk(act == exp, tag, $sformatf("flags at count %0d", n), act, exp);
    endtask

    task automatic do_reset(input bit load_mode);
        rst_n  = 1'b0;
        wr_en1 = 1'b0;
        wr_en2 = !load_mode;
        rd_en1 = 1'b0;
        rd_en2 = 1'b0;
        repeat (4) @(negedge wclk);
        rst_n  = 1'b1;
        wr_en2 = 1'b0;
        @(negedge wclk);
        mq.delete();
    endtask

    task automatic push(input logic [DW-1:0] d);
        wr_en1 = 1'b1; wr_en2 = 1'b1; wr_data = d;
        @(negedge wclk);
        wr_en1 = 1'b0; wr_en2 = 1'b0;
    endtask

    task automatic load(input logic [DW-1:0] d);
        wr_en1 = 1'b1; wr_en2 = 1'b0; wr_data = d;
        @(negedge wclk);
        wr_en1 = 1'b0;
    endtask

    task automatic pop();
        rd_en1 = 1'b1; rd_en2 = 1'b1;
        @(negedge wclk);
        rd_en1 = 1'b0; rd_en2 = 1'b0;
    endtask

    task automatic settle();
        repeat (4) @(negedge wclk);
    endtask

    // Fill to DEPTH and drain to 0, checking flags at every level (R10)
    task automatic sweep(input string tag, input int aeo, input int afo);
        logic [DW-1:0] exp;
        for (int n = 1; n <= DEPTH; n++) begin
            exp = DW'((n * 37 + 5) % 512);
            push(exp);
            mq.push_back(exp);
            settle();
            chk_flags(tag, n, aeo, afo);
        end
        for (int n = DEPTH - 1; n >= 0; n--) begin
            exp = mq.pop_front();
            pop();
            chk(rd_q == exp, "R5", "popped word", int'(rd_q), int'(exp));
            settle();
            chk_flags(tag, n, aeo, afo);
        end
    endtask

    initial begin
        logic [DW-1:0] held;
        // ---------- dual-enable mode ----------
        do_reset(1'b0);
        chk_flags("R7", 0, 7, 7);
        chk(rd_q == '0, "R7", "rd_q after reset", int'(rd_q), 0);

        rd_oe = 1'b0;
        #1;
        chk(rd_q_en == 1'b0 && rd_q == '0, "R6", "disabled output", int'(rd_q_en), 0);
        rd_oe = 1'b1;
        #1;
        chk(rd_q_en == 1'b1, "R6", "enabled output", int'(rd_q_en), 1);

        // one-enable writes do nothing; data 0 would shrink AE offset if loaded
        wr_en1 = 1'b1; wr_en2 = 1'b0; wr_data = '0;
        @(negedge wclk);
        wr_en1 = 1'b0; wr_en2 = 1'b1; wr_data = 9'h1AB;
        @(negedge wclk);
        wr_en2 = 1'b0;
        settle();
        chk(empty == 1'b1, "R1", "empty after one-enable writes", int'(empty), 1);

        // R8 latency: write into empty, empty falls on third read edge
        wr_en1 = 1'b1; wr_en2 = 1'b1; wr_data = 9'h0C3;
        @(posedge wclk);
        @(negedge wclk);
        wr_en1 = 1'b0; wr_en2 = 1'b0;
        chk(empty == 1'b1, "R8", "empty after edge e", int'(empty), 1);
        @(negedge wclk);
        @(negedge wclk);
        chk(empty == 1'b1, "R8", "empty after edge e+2", int'(empty), 1);
        @(negedge wclk);
        chk(empty == 1'b0, "R8", "empty after edge e+3", int'(empty), 0);
        chk(aempty == 1'b1, "R12", "aempty at count 1 with offset 7", int'(aempty), 1);

        // R2: single read enables do not pop
        rd_en1 = 1'b1; @(negedge wclk); rd_en1 = 1'b0;
        rd_en2 = 1'b1; @(negedge wclk); rd_en2 = 1'b0;
        settle();
        chk(empty == 1'b0 && rd_q == '0, "R2", "single-enable read", int'(rd_q), 0);

        pop();
        chk(rd_q == 9'h0C3, "R5", "first word", int'(rd_q), 'h0C3);
        chk(empty == 1'b1, "R8", "empty right after last pop", int'(empty), 1);
        settle();

        sweep("R10", 7, 7);

        // R9: full on the filling edge, release three edges after a read
        for (int i = 0; i < DEPTH - 1; i++) begin
            push(DW'(i + 100));
            mq.push_back(DW'(i + 100));
        end
        settle();
        chk(full == 1'b0, "R9", "full at DEPTH-1", int'(full), 0);
        push(9'h0EE);
        mq.push_back(9'h0EE);
        chk(full == 1'b1, "R9", "full right after filling write", int'(full), 1);
        push(9'h155);   // dropped (R3)
        settle();
        chk(full == 1'b1, "R3", "full after overflow attempt", int'(full), 1);

        rd_en1 = 1'b1; rd_en2 = 1'b1;
        @(posedge wclk);
        @(negedge wclk);
        rd_en1 = 1'b0; rd_en2 = 1'b0;
        held = mq.pop_front();
        chk(rd_q == held, "R5", "word at full", int'(rd_q), int'(held));
        chk(full == 1'b1, "R9", "full after read edge e", int'(full), 1);
        @(negedge wclk);
        @(negedge wclk);
        chk(full == 1'b1, "R9", "full after edge e+2", int'(full), 1);
        @(negedge wclk);
        chk(full == 1'b0, "R9", "full after edge e+3", int'(full), 0);

        begin
            int bad;
            bad = 0;
            while (mq.size() > 0) begin
                held = mq.pop_front();
                pop();
                if (rd_q != held) bad++;
            end
            chk(bad == 0, "R3", "drain after overflow mismatches", bad, 0);
        end
        settle();
        chk(empty == 1'b1, "R3", "empty after drain, no extra word", int'(empty), 1);

        // R4: reads while empty
        held = rd_q;
        pop();
        pop();
        settle();
        chk(rd_q == held, "R4", "rd_q held on empty read", int'(rd_q), int'(held));
        push(9'h07A);
        settle();
        pop();
        chk(rd_q == 9'h07A, "R4", "next word after empty reads", int'(rd_q), 'h07A);
        settle();

        // ---------- load mode ----------
        do_reset(1'b1);
        // first round: AE=45 (lo 5 hi 5), AF=50 (lo 2 hi 6)
        load({6'b101010, 3'd5});
        load(9'd5);
        load(9'd2);
        load(9'd6);
        // second round after wrap: AE=3 (lo 3 hi 0), AF=10 (lo 2 hi 1)
        load({6'b111111, 3'd3});
        load({6'b110000, 3'd0});
        load(9'd2);
        load(9'd1);
        settle();
        chk_flags("R11", 0, 3, 10);
        sweep("R11", 3, 10);

        // ---------- independent clocks (R13) ----------
        tied = 1'b0;
        do_reset(1'b0);
        begin
            int got, bad;
            bit prev;
            got = 0; bad = 0; prev = 1'b0;
            fork
                begin
                    for (int i = 0; i < 40; i++) begin
                        while (full) @(negedge wclk);
                        mq.push_back(DW'(i * 11 + 3));
                        push(DW'(i * 11 + 3));
                    end
                end
                begin
                    rd_en2 = 1'b1;
                    while (got < 40) begin
                        @(negedge rd_clk);
                        if (prev) begin
                            held = mq.pop_front();
                            if (rd_q != held) bad++;
                            got++;
                        end
                        rd_en1 = !empty && (got < 40);
                        prev   = rd_en1;
                    end
                    rd_en1 = 1'b0;
                    rd_en2 = 1'b0;
                end
            join
            chk(bad == 0, "R13", "async order mismatches", bad, 0);
            chk(got == 40, "R13", "async words read", got, 40);
        end

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge wclk);
        if (!finished) begin
            n_errs++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
            $finish;
        end
    end
endmodule